// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank SDRAM pin interface and follows, cycle by cycle, what the memory would do with the command stream it receives. On every rising clock edge it samples chip select, the three strobe/enable pins, the bank select, the address and clock enable. It decodes one command and updates a small state machine for each bank: idle, opening, open, reading, writing or closing. Two global conditions sit beside the banks: an auto-refresh busy window and a self-refresh hold.

Commands that do not fit the current state are flagged as command errors. Commands that arrive before a required delay has run out are flagged as timing errors. Both flags are sticky until reset, and the offending command is dropped without changing any state. When a read or write is accepted, a one-cycle pulse tells an attached data path which bank and column the burst starts at and whether auto-precharge was requested. All delays are parameters counted in clocks, and each must be at least 2.

The address port is `AP_BIT+1` bits wide. The column occupies the bits below `AP_BIT`. Row bits beyond that are not needed, because rows are not tracked.

Top module: `sdc_tracker`

## Requirements
- R1: With sel_n low, {row_strobe_n, col_strobe_n, wr_en_n} decode as: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop. With sel_n high, the pins are ignored and no state or flag changes.
- R2: The bank_state field for bank i is bank_state[3i+2:3i], encoded as 0 idle, 1 opening, 2 open, 3 reading, 4 writing, 5 closing. An activate at edge k moves an idle bank to opening, and the bank becomes open in time for a read or write at edge k+T_RCD. A read or write to an opening bank is a timing error.
- R3: A read or write is accepted only by a bank that is open, or that is in a burst without auto-precharge. On acceptance, rd_accept or wr_accept pulses for one cycle after that edge, together with acc_bank, acc_col (address bits below AP_BIT) and acc_autopre (address bit AP_BIT). A read or write to an idle bank, or to a bank in an auto-precharge burst, is a command error.
- R4: An accepted burst keeps the bank reading or writing for BURST cycles after the command edge, after which it returns to open. A burst stop ends a non-auto-precharge burst at once and returns the bank to open.
- R5: A read or write with address bit AP_BIT set closes the bank by itself when the burst ends. The bank then turns idle T_RP cycles later. Other banks can be activated in the meantime.
- R6: A precharge earlier than T_RAS clocks after the activate is a timing error. With address bit AP_BIT set, a precharge addresses every bank.
- R7: A closing bank turns idle so that an activate at edge p+T_RP is accepted, where p is the precharge edge. An earlier activate is a timing error. No-op and burst stop leave the countdown alone.
- R8: A refresh with any bank not idle is a command error. An accepted refresh raises refresh_busy, and any command other than no-op or burst stop before edge f+T_RFC is a timing error.
- R9: A refresh sampled with clk_en low while all banks are idle enters self-refresh. Commands are ignored while clk_en stays low. The first edge with clk_en high leaves self-refresh. The same entry with a bank not idle is a command error.
- R10: A mode set with all banks idle is accepted; with a bank not idle it is a command error. An activate before edge m+T_MRD is a timing error.
- R11: Outside self-refresh, an edge with clk_en low ignores the command and freezes every counter and bank state.
- R12: After reset every bank is idle and all outputs are low. err_cmd and err_timing stay high once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable pin |
| sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bank_sel | input | BA_W | Bank select |
| addr | input | AP_BIT+1 | Column address and auto-precharge / all-bank bit |
| bank_state | output | 3*NUM_BANKS | Per-bank state codes |
| self_refresh | output | 1 | Device is held in self-refresh |
| refresh_busy | output | 1 | Auto-refresh window running |
| rd_accept | output | 1 | Read accepted on the last edge |
| wr_accept | output | 1 | Write accepted on the last edge |
| acc_bank | output | BA_W | Bank of the accepted access |
| acc_col | output | AP_BIT | Start column of the accepted access |
| acc_autopre | output | 1 | Accepted access closes its bank afterwards |
| err_cmd | output | 1 | Sticky command-error flag |
| err_timing | output | 1 | Sticky timing-error flag |

## Verification
The main function is driven with a series of command patterns, each built to separate one pair of outcomes:
- An activate followed by a read one clock too early versus on time separates the timing check from normal acceptance.
- A read to an idle bank separates a command error from a timing error.
- Auto-precharge bursts interleaved with an activate to a second bank show that banks run independently.
- Precharges issued before and after the row-active minimum, and activates issued before and after the precharge delay, pin down the exact edge at which each window ends.
- Refresh, self-refresh and mode set are each tried with all banks idle and with a bank open, to separate acceptance from a state error.
- Clock-enable-low stretches inserted during an opening delay show that counting resumes where it stopped.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MODE, CMD_BST
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPENING = 3'd1,
    BK_OPEN    = 3'd2,
    BK_RD      = 3'd3,
    BK_WR      = 3'd4,
    BK_CLOSING = 3'd5
  } bank_e;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic sel_n,
  input  logic row_strobe_n,
  input  logic col_strobe_n,
  input  logic wr_en_n,
  output cmd_e cmd
);
  // R1: deselect reads as no-op; strobes decode only with select low
  always_comb begin
    if (sel_n) cmd = CMD_NOP;
    else begin
      unique case ({row_strobe_n, col_strobe_n, wr_en_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MODE;
        default: cmd = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdc_global.sv
module sdc_global
  import sdc_pkg::*;
#(
  parameter int T_MRD = 2,
  parameter int T_RFC = 5,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  cmd_e cmd,
  input  logic all_idle,
  output logic run,
  output cmd_e bank_cmd,
  output logic mode_wait,
  output logic self_ref,
  output logic ref_busy,
  output logic err_cmd,
  output logic err_tim
);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);

  logic             sr_q, sr_n;
  logic [CNT_W-1:0] mrd_q, mrd_n, rfc_q, rfc_n;

  assign run       = clk_en && !sr_q;
  assign self_ref  = sr_q;
  assign ref_busy  = (rfc_q != '0);
  assign mode_wait = (mrd_q != '0);

  always_comb begin
    sr_n = sr_q; mrd_n = mrd_q; rfc_n = rfc_q;
    bank_cmd = CMD_NOP; err_cmd = 1'b0; err_tim = 1'b0;
    if (sr_q) begin
      if (clk_en) sr_n = 1'b0;                 // R9 exit
    end else if (!clk_en) begin
      if (cmd == CMD_REF) begin                // R9 entry, R11 freeze otherwise
        if (!all_idle)     err_cmd = 1'b1;
        else if (ref_busy) err_tim = 1'b1;
        else               sr_n = 1'b1;
      end
    end else begin
      if (mrd_q != '0) mrd_n = mrd_q - 1'b1;
      if (rfc_q != '0) rfc_n = rfc_q - 1'b1;
      if (ref_busy && cmd != CMD_NOP && cmd != CMD_BST) err_tim = 1'b1;   // R8
      else begin
        unique case (cmd)
          CMD_REF:  if (all_idle) rfc_n = LD_RFC; else err_cmd = 1'b1;
          CMD_MODE: if (all_idle) mrd_n = LD_MRD; else err_cmd = 1'b1;
          default:  bank_cmd = cmd;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= 1'b0; mrd_q <= '0; rfc_q <= '0;
    end else begin
      sr_q <= sr_n; mrd_q <= mrd_n; rfc_q <= rfc_n;
    end
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int BURST = 4,
  parameter int CNT_W = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  cmd_e  cmd,
  input  logic  hit,
  input  logic  ap,
  input  logic  mode_wait,
  output bank_e state,
  output logic  err_cmd,
  output logic  err_tim,
  output logic  rd_go,
  output logic  wr_go
);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_BL  = CNT_W'(BURST);

  bank_e            st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, ras_q, ras_n;
  logic             ap_q, ap_n;
  logic             in_burst, row_up;

  assign state    = st_q;
  assign in_burst = (st_q == BK_RD) || (st_q == BK_WR);
  assign row_up   = in_burst || (st_q == BK_OPEN) || (st_q == BK_OPENING);

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; ras_n = ras_q; ap_n = ap_q;
    err_cmd = 1'b0; err_tim = 1'b0; rd_go = 1'b0; wr_go = 1'b0;
    if (run) begin
      if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
      if (ras_q != '0) ras_n = ras_q - 1'b1;
      if (cnt_q == ONE) begin
        unique case (st_q)
          BK_OPENING: st_n = BK_OPEN;                        // R2
          BK_RD, BK_WR: begin                                // R4, R5
            if (ap_q) begin st_n = BK_CLOSING; cnt_n = LD_RP; ap_n = 1'b0; end
            else st_n = BK_OPEN;
          end
          BK_CLOSING: st_n = BK_IDLE;                        // R7
          default: ;
        endcase
      end
      unique case (cmd)
        CMD_ACT: if (hit) begin
          if (st_q == BK_IDLE && !mode_wait) begin
            st_n = BK_OPENING; cnt_n = LD_RCD; ras_n = LD_RAS;
          end else if (st_q == BK_IDLE || st_q == BK_CLOSING) err_tim = 1'b1;  // R10, R7
          else err_cmd = 1'b1;
        end
        CMD_RD, CMD_WR: if (hit) begin
          if (st_q == BK_OPEN || (in_burst && !ap_q)) begin   // R3
            st_n  = (cmd == CMD_RD) ? BK_RD : BK_WR;
            cnt_n = LD_BL; ap_n = ap;
            rd_go = (cmd == CMD_RD); wr_go = (cmd == CMD_WR);
          end else if (st_q == BK_OPENING) err_tim = 1'b1;    // R2
          else err_cmd = 1'b1;
        end
        CMD_PRE: if ((hit || ap) && row_up) begin             // R6
          if (ras_q == '0) begin st_n = BK_CLOSING; cnt_n = LD_RP; ap_n = 1'b0; end
          else err_tim = 1'b1;
        end
        CMD_BST: if (in_burst && !ap_q) begin st_n = BK_OPEN; cnt_n = '0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BK_IDLE; cnt_q <= '0; ras_q <= '0; ap_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; ras_q <= ras_n; ap_q <= ap_n;
    end
  end
endmodule

// File: rtl/sdc_tracker.sv
module sdc_tracker
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 5,
  parameter int BURST     = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clk_en,
  input  logic                   sel_n,
  input  logic                   row_strobe_n,
  input  logic                   col_strobe_n,
  input  logic                   wr_en_n,
  input  logic [BA_W-1:0]        bank_sel,
  input  logic [AP_BIT:0]        addr,
  output logic [3*NUM_BANKS-1:0] bank_state,
  output logic                   self_refresh,
  output logic                   refresh_busy,
  output logic                   rd_accept,
  output logic                   wr_accept,
  output logic [BA_W-1:0]        acc_bank,
  output logic [AP_BIT-1:0]      acc_col,
  output logic                   acc_autopre,
  output logic                   err_cmd,
  output logic                   err_timing
);
  localparam int M1    = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M2    = (T_RAS > BURST) ? T_RAS : BURST;
  localparam int M3    = (T_MRD > T_RFC) ? T_MRD : T_RFC;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int MAXT  = (M12 > M3) ? M12 : M3;
  localparam int CNT_W = $clog2(MAXT + 1);

  cmd_e                 cmd, bank_cmd;
  logic                 run, mode_wait, g_err_cmd, g_err_tim;
  logic [NUM_BANKS-1:0] idle, b_err_cmd, b_err_tim, b_rd, b_wr;

  sdc_decode u_dec (
    .sel_n(sel_n), .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
    .wr_en_n(wr_en_n), .cmd(cmd)
  );

  sdc_global #(.T_MRD(T_MRD), .T_RFC(T_RFC), .CNT_W(CNT_W)) u_glb (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd(cmd), .all_idle(&idle),
    .run(run), .bank_cmd(bank_cmd), .mode_wait(mode_wait),
    .self_ref(self_refresh), .ref_busy(refresh_busy),
    .err_cmd(g_err_cmd), .err_tim(g_err_tim)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bank_e st;
    sdc_bank #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .BURST(BURST), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .run(run), .cmd(bank_cmd),
      .hit(bank_sel == BA_W'(i)), .ap(addr[AP_BIT]), .mode_wait(mode_wait),
      .state(st), .err_cmd(b_err_cmd[i]), .err_tim(b_err_tim[i]),
      .rd_go(b_rd[i]), .wr_go(b_wr[i])
    );
    assign idle[i]            = (st == BK_IDLE);
    assign bank_state[3*i+:3] = st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_accept <= 1'b0; wr_accept <= 1'b0; acc_bank <= '0; acc_col <= '0;
      acc_autopre <= 1'b0; err_cmd <= 1'b0; err_timing <= 1'b0;
    end else begin
      rd_accept  <= |b_rd;
      wr_accept  <= |b_wr;
      err_cmd    <= err_cmd | g_err_cmd | (|b_err_cmd);       // R12 sticky
      err_timing <= err_timing | g_err_tim | (|b_err_tim);
      if (|{b_rd, b_wr}) begin
        acc_bank    <= bank_sel;
        acc_col     <= addr[AP_BIT-1:0];
        acc_autopre <= addr[AP_BIT];
      end
    end
  end
endmodule

// File: rtl/sdc_tracker_chk.sv
module sdc_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clk_en,
  input logic [3*NUM_BANKS-1:0] bank_state,
  input logic                   self_refresh,
  input logic                   refresh_busy,
  input logic                   rd_accept,
  input logic                   wr_accept,
  input logic [BA_W-1:0]        acc_bank,
  input logic                   err_cmd,
  input logic                   err_timing
);
  logic [2:0] acc_st;
  always_comb begin
    acc_st = 3'd0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (acc_bank == BA_W'(i)) acc_st = bank_state[3*i+:3];
  end

  assert_accept_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_accept && wr_accept));
  assert_rd_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |-> acc_st == 3'd3);
  assert_wr_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> acc_st == 3'd4);
  assert_cmd_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmd |=> err_cmd);
  assert_tim_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_timing |=> err_timing);
  assert_selfref_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh |-> bank_state == '0);
  assert_refbusy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_busy |-> bank_state == '0);
  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !self_refresh) |=> $stable(bank_state));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cl
    assert_close_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state[3*i+:3] == 3'd5 |=> (bank_state[3*i+:3] == 3'd5 || bank_state[3*i+:3] == 3'd0));
  end
endmodule

bind sdc_tracker sdc_tracker_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bank_state(bank_state),
  .self_refresh(self_refresh), .refresh_busy(refresh_busy),
  .rd_accept(rd_accept), .wr_accept(wr_accept), .acc_bank(acc_bank),
  .err_cmd(err_cmd), .err_timing(err_timing)
);

// File: tb/test_sdc_tracker.sv
module test_sdc_tracker;
  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, REF = 3'b001, MRS = 3'b000, BST = 3'b110;
  localparam logic [10:0] APB = 11'h400;

  logic        clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1;
  logic        sel_n = 1'b1, row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1;
  logic [1:0]  bank_sel = '0;
  logic [10:0] addr = '0;
  logic [11:0] bank_state;
  logic        self_refresh, refresh_busy, rd_accept, wr_accept, acc_autopre, err_cmd, err_timing;
  logic [1:0]  acc_bank;
  logic [9:0]  acc_col;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdc_tracker i_sdc_tracker (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n),
    .bank_sel(bank_sel), .addr(addr), .bank_state(bank_state),
    .self_refresh(self_refresh), .refresh_busy(refresh_busy),
    .rd_accept(rd_accept), .wr_accept(wr_accept), .acc_bank(acc_bank),
    .acc_col(acc_col), .acc_autopre(acc_autopre), .err_cmd(err_cmd), .err_timing(err_timing)
  );

  function automatic int st(int i);
    return int'(bank_state[i*3+:3]);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive one command for one edge; returns at the following falling edge
  task automatic op(input logic [2:0] c, input logic [1:0] b = 2'd0,
                    input logic [10:0] a = '0, input logic ke = 1'b1, input logic cs = 1'b0);
    sel_n = cs; {row_strobe_n, col_strobe_n, wr_en_n} = c;
    bank_sel = b; addr = a; clk_en = ke;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sel_n = 1'b1; {row_strobe_n, col_strobe_n, wr_en_n} = NOP; clk_en = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 states idle", int'(bank_state), 0);
    chk("R12 err_cmd", int'(err_cmd), 0);
    chk("R12 err_timing", int'(err_timing), 0);
    chk("R12 rd_accept", int'(rd_accept), 0);
  endtask

  task automatic t_deselect();
    do_reset();
    op(ACT, 2'd1, '0, 1'b1, 1'b1);
    chk("R1 deselect bank1 idle", st(1), 0);
    chk("R1 deselect no error", int'(err_cmd | err_timing), 0);
  endtask

  task automatic t_rcd();
    do_reset();
    op(ACT, 2'd0);
    chk("R2 opening", st(0), 1);
    op(NOP);
    op(RD, 2'd0, 11'd5);
    chk("R2 early read no accept", int'(rd_accept), 0);
    chk("R2 early read timing err", int'(err_timing), 1);
    chk("R2 early read no cmd err", int'(err_cmd), 0);
    chk("R2 bank open", st(0), 2);
  endtask

  task automatic t_burst();
    do_reset();
    op(ACT, 2'd2); op(NOP); op(NOP);
    op(RD, 2'd2, 11'd7);
    chk("R3 rd_accept", int'(rd_accept), 1);
    chk("R3 acc_bank", int'(acc_bank), 2);
    chk("R3 acc_col", int'(acc_col), 7);
    chk("R3 acc_autopre", int'(acc_autopre), 0);
    chk("R4 reading", st(2), 3);
    op(NOP);
    chk("R3 pulse one cycle", int'(rd_accept), 0);
    op(NOP); op(NOP);
    chk("R4 still reading", st(2), 3);
    op(NOP);
    chk("R4 back open", st(2), 2);
    op(WR, 2'd2, 11'd3);
    chk("R3 wr_accept", int'(wr_accept), 1);
    chk("R4 writing", st(2), 4);
    op(BST);
    chk("R4 burst stop open", st(2), 2);
    chk("R4 no errors", int'(err_cmd | err_timing), 0);
  endtask

  task automatic t_idle_read();
    do_reset();
    op(RD, 2'd1, 11'd1);
    chk("R3 idle read cmd err", int'(err_cmd), 1);
    chk("R3 idle read no accept", int'(rd_accept), 0);
    chk("R3 idle read no timing err", int'(err_timing), 0);
  endtask

  task automatic t_autopre();
    do_reset();
    op(ACT, 2'd0); op(NOP); op(NOP);
    op(RD, 2'd0, APB | 11'd9);
    chk("R5 acc_autopre", int'(acc_autopre), 1);
    op(ACT, 2'd1);
    chk("R5 other bank opening", st(1), 1);
    op(NOP); op(NOP);
    chk("R5 still reading", st(0), 3);
    op(NOP);
    chk("R5 closing after burst", st(0), 5);
    chk("R5 other bank open", st(1), 2);
    op(NOP);
    chk("R5 still closing", st(0), 5);
    op(NOP);
    chk("R5 idle after tRP", st(0), 0);
    chk("R5 no errors", int'(err_cmd | err_timing), 0);
  endtask

  task automatic t_ras();
    do_reset();
    op(ACT, 2'd3); op(NOP); op(NOP);
    op(PRE, 2'd3);
    chk("R6 early precharge timing err", int'(err_timing), 1);
    chk("R6 bank stays open", st(3), 2);
    op(NOP); op(NOP);
    op(PRE, 2'd0, APB);
    chk("R6 precharge all closes bank3", st(3), 5);
    chk("R6 idle bank0 untouched", st(0), 0);
    chk("R6 no cmd err", int'(err_cmd), 0);
  endtask

  task automatic t_rp();
    do_reset();
    op(ACT, 2'd0);
    repeat (5) op(NOP);
    op(PRE, 2'd0);
    chk("R7 closing", st(0), 5);
    chk("R7 legal precharge", int'(err_timing), 0);
    op(ACT, 2'd0);
    chk("R7 early activate timing err", int'(err_timing), 1);
    chk("R7 still closing", st(0), 5);
    op(BST);
    chk("R7 idle, burst stop no effect", st(0), 0);
    op(ACT, 2'd0);
    chk("R7 activate accepted", st(0), 1);
  endtask

  task automatic t_refresh();
    do_reset();
    op(ACT, 2'd1);
    op(REF);
    chk("R8 refresh with open bank cmd err", int'(err_cmd), 1);
    chk("R8 not busy", int'(refresh_busy), 0);
    do_reset();
    op(REF);
    chk("R8 busy", int'(refresh_busy), 1);
    op(ACT, 2'd0);
    chk("R8 activate during refresh timing err", int'(err_timing), 1);
    chk("R8 bank idle", st(0), 0);
    op(NOP); op(NOP);
    chk("R8 busy at f+3", int'(refresh_busy), 1);
    op(NOP);
    chk("R8 done at f+4", int'(refresh_busy), 0);
    op(ACT, 2'd0);
    chk("R8 activate after refresh", st(0), 1);
    chk("R8 no cmd err", int'(err_cmd), 0);
  endtask

  task automatic t_selfref();
    do_reset();
    op(REF, 2'd0, '0, 1'b0);
    chk("R9 entered", int'(self_refresh), 1);
    op(NOP, 2'd0, '0, 1'b0);
    op(ACT, 2'd0, '0, 1'b0);
    chk("R9 held", int'(self_refresh), 1);
    chk("R9 activate ignored", st(0), 0);
    chk("R9 no errors", int'(err_cmd | err_timing), 0);
    op(NOP);
    chk("R9 exit", int'(self_refresh), 0);
    op(ACT, 2'd0);
    chk("R9 activate after exit", st(0), 1);
    do_reset();
    op(ACT, 2'd0); op(NOP); op(NOP);
    op(REF, 2'd0, '0, 1'b0);
    chk("R9 entry with open bank cmd err", int'(err_cmd), 1);
    chk("R9 not entered", int'(self_refresh), 0);
  endtask

  task automatic t_mode();
    do_reset();
    op(MRS, 2'd0, 11'h23);
    chk("R10 mode set accepted", int'(err_cmd), 0);
    op(ACT, 2'd0);
    chk("R10 early activate timing err", int'(err_timing), 1);
    chk("R10 bank idle", st(0), 0);
    op(ACT, 2'd0);
    chk("R10 activate accepted", st(0), 1);
    op(MRS);
    chk("R10 mode set with bank busy cmd err", int'(err_cmd), 1);
  endtask

  task automatic t_suspend();
    do_reset();
    op(ACT, 2'd0);
    op(NOP, 2'd0, '0, 1'b0);
    op(RD, 2'd0, 11'd2, 1'b0);
    op(NOP, 2'd0, '0, 1'b0);
    chk("R11 frozen opening", st(0), 1);
    chk("R11 read ignored", int'(rd_accept), 0);
    chk("R11 no errors", int'(err_cmd | err_timing), 0);
    op(NOP);
    chk("R11 resumed, still opening", st(0), 1);
    op(NOP);
    chk("R11 open after resumed count", st(0), 2);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_deselect();
    t_rcd();
    t_burst();
    t_idle_read();
    t_autopre();
    t_ras();
    t_rp();
    t_refresh();
    t_selfref();
    t_mode();
    t_suspend();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule